// File: doc/BRIEF.md
# Interrupt Entry Sequencer

This block runs the hardware part of entering an interrupt for a small 8-bit microcontroller core. At each instruction boundary that the core signals, it looks at a reset request and a vector of pending interrupt sources. A request is taken only while the global interrupt enable is set and the core is not about to skip its next instruction. A reset request wins over every source. Among the sources, the lowest set bit wins.

Once a request is taken, the sequencer captures the current word program counter and the stack pointer. It then writes the return address into data memory one byte per clock. The least significant byte goes first, at the stack pointer, and the address falls by one after each byte. In the cycle after the last byte it issues a single load pulse. That pulse carries the new program counter (a vector base plus the vector number times the slot size), the new stack pointer, a request to clear the global enable, and a one-hot mask that clears only the serviced pending bit.

The number of bytes pushed comes from the program counter width. The slot size comes from whether the core has long jump and call instructions.

Top module: `irq_entry_seq`

## Requirements
- R1: A request is accepted only in a cycle where `boundary_i`=1, `gie_i`=1, `skip_i`=0 and either `rst_req_i`=1 or `pend_i`≠0. This rule holds for the reset request as well. In any other idle cycle, `busy_o`, `mem_we_o` and `load_o` stay 0.
- R2: A reset request has priority over every pending source and uses vector 0. When a reset request is serviced, `rst_ack_o`=1 and `pend_clr_o`=0 in the load cycle.
- R3: When no reset request is present, the lowest set bit index i of `pend_i` wins and uses vector i+1.
- R4: In the load cycle, `pc_new_o` = VEC_BASE + vector × slot. The slot is 2 words when LONG_JUMP=1 and 1 word otherwise.
- R5: The return address is written least significant byte first. The first write goes to the captured stack pointer and each later write goes one address lower. In the load cycle, `sp_new_o` = captured SP − PC_BYTES.
- R6: Exactly PC_BYTES writes (1, 2 or 3) are issued, one per clock, starting in the cycle after acceptance.
- R7: `load_o` and `gie_clr_o` pulse for one cycle, in the cycle right after the last write.
- R8: `pend_clr_o` is nonzero only in the load cycle. When it is nonzero it has exactly the winning source's bit set.
- R9: `busy_o` is 1 from the cycle after acceptance through the load cycle, and 0 after that. Requests that arrive while busy are ignored.
- R10: No request is accepted while `skip_i`=1, even at a boundary with the enable set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| boundary_i | input | 1 | Instruction boundary strobe from the core |
| skip_i | input | 1 | The next instruction will be skipped |
| gie_i | input | 1 | Global interrupt enable |
| rst_req_i | input | 1 | Reset request |
| pend_i | input | NUM_SRC | Pending interrupt sources |
| pc_i | input | 8*PC_BYTES | Current word program counter (the return address) |
| sp_i | input | SP_W | Current stack pointer |
| busy_o | output | 1 | Entry sequence in progress |
| mem_we_o | output | 1 | Data memory write strobe |
| mem_addr_o | output | SP_W | Data memory write address |
| mem_wdata_o | output | 8 | Data memory write byte |
| load_o | output | 1 | Program counter and stack pointer load pulse |
| pc_new_o | output | 8*PC_BYTES | Vector target address |
| sp_new_o | output | SP_W | Stack pointer after the pushes |
| gie_clr_o | output | 1 | Clear the global enable |
| pend_clr_o | output | NUM_SRC | One-hot mask of the pending bit to clear |
| rst_ack_o | output | 1 | Reset request was serviced |

## Verification
The bench targets these faults:
- **Suppression:** a design that ignores the enable, the skip flag or the boundary strobe would start a push sequence when it should stay idle.
- **Priority:** a design with the priority reversed (highest bit first) or with reset below the sources would jump to the wrong slot and clear the wrong pending bit.
- **Ordering and timing:** a design that pushes the bytes high first, steps the address upward, or issues one write too many or too few would write the wrong byte or address in some cycle, and its load pulse would arrive a cycle early or late.
- **Busy-time requests:** strobes and requests are also driven while busy; a design that accepts them would restart the sequence partway through.

// File: rtl/irq_seq_pkg.sv
package irq_seq_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_PUSH = 2'd1,
    ST_LOAD = 2'd2
  } seq_state_e;
endpackage

// File: rtl/irq_prio_pick.sv
module irq_prio_pick #(
  parameter int NUM_SRC = 8,
  localparam int IDX_W = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1
) (
  input  logic [NUM_SRC-1:0] pend_i,
  output logic               any_o,
  output logic [NUM_SRC-1:0] oh_o,
  output logic [IDX_W-1:0]   idx_o
);
  logic [NUM_SRC:0] below;

  assign below[0] = 1'b0;

  // The lowest set bit wins: a bit is granted only when nothing below it is set
  for (genvar g = 0; g < NUM_SRC; g++) begin : g_chain
    assign below[g+1] = below[g] | pend_i[g];
    assign oh_o[g]    = pend_i[g] & ~below[g];
  end

  assign any_o = below[NUM_SRC];

  always_comb begin
    idx_o = '0;
    for (int k = 0; k < NUM_SRC; k++) begin
      if (oh_o[k]) idx_o = idx_o | IDX_W'(k);
    end
  end
endmodule

// File: rtl/irq_vec_target.sv
module irq_vec_target #(
  parameter int          NUM_SRC   = 8,
  parameter int          PC_W      = 24,
  parameter int unsigned VEC_BASE  = 0,
  parameter bit          LONG_JUMP = 1'b1,
  localparam int IDX_W = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1
) (
  input  logic             is_reset_i,
  input  logic [IDX_W-1:0] idx_i,
  output logic [PC_W-1:0]  pc_o
);
  logic [PC_W-1:0] vec;

  // Vector 0 belongs to the reset request; source i uses vector i+1
  assign vec = is_reset_i ? '0 : PC_W'(idx_i) + PC_W'(1);

  if (LONG_JUMP) begin : g_two_word
    assign pc_o = PC_W'(VEC_BASE) + {vec[PC_W-2:0], 1'b0};
  end else begin : g_one_word
    assign pc_o = PC_W'(VEC_BASE) + vec;
  end
endmodule

// File: rtl/irq_seq_ctrl.sv
module irq_seq_ctrl
  import irq_seq_pkg::*;
#(
  parameter int NUM_SRC  = 8,
  parameter int PC_BYTES = 3,
  parameter int SP_W     = 16,
  localparam int PC_W  = 8 * PC_BYTES,
  localparam int IDX_W = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1,
  localparam int CNT_W = (PC_BYTES > 1) ? $clog2(PC_BYTES) : 1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               accept_i,
  input  logic               is_reset_i,
  input  logic [NUM_SRC-1:0] win_oh_i,
  input  logic [IDX_W-1:0]   win_idx_i,
  input  logic [PC_W-1:0]    pc_i,
  input  logic [SP_W-1:0]    sp_i,
  output logic               idle_o,
  output logic               busy_o,
  output logic               mem_we_o,
  output logic [SP_W-1:0]    mem_addr_o,
  output logic [7:0]         mem_wdata_o,
  output logic               load_o,
  output logic [SP_W-1:0]    sp_new_o,
  output logic               gie_clr_o,
  output logic [NUM_SRC-1:0] pend_clr_o,
  output logic               rst_ack_o,
  output logic               lat_reset_o,
  output logic [IDX_W-1:0]   lat_idx_o
);
  seq_state_e                 state_q, state_d;
  logic [CNT_W-1:0]           cnt_q, cnt_d;
  logic [SP_W-1:0]            sp_q, sp_d;
  logic [PC_BYTES-1:0][7:0]   ret_q;
  logic                       rst_q;
  logic [NUM_SRC-1:0]         oh_q;
  logic [IDX_W-1:0]           idx_q;
  logic                       last_push;
  logic                       sp_en;

  assign last_push = (cnt_q == CNT_W'(PC_BYTES - 1));
  assign sp_en     = accept_i | (state_q == ST_PUSH);

  always_comb begin
    state_d = state_q;
    cnt_d   = cnt_q;
    sp_d    = sp_q;
    unique case (state_q)
      ST_IDLE: begin
        if (accept_i) begin
          state_d = ST_PUSH;
          cnt_d   = '0;
          sp_d    = sp_i;
        end
      end
      ST_PUSH: begin
        sp_d = sp_q - SP_W'(1);
        if (last_push) state_d = ST_LOAD;
        else           cnt_d   = cnt_q + CNT_W'(1);
      end
      ST_LOAD: state_d = ST_IDLE;
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      cnt_q   <= '0;
      sp_q    <= '0;
      ret_q   <= '0;
      rst_q   <= 1'b0;
      oh_q    <= '0;
      idx_q   <= '0;
    end else begin
      state_q <= state_d;
      cnt_q   <= cnt_d;
      if (sp_en) sp_q <= sp_d;
      if (accept_i) begin
        ret_q <= pc_i;
        rst_q <= is_reset_i;
        oh_q  <= is_reset_i ? '0 : win_oh_i;
        idx_q <= win_idx_i;
      end
    end
  end

  assign idle_o      = (state_q == ST_IDLE);
  assign busy_o      = ~idle_o;
  assign mem_we_o    = (state_q == ST_PUSH);
  assign mem_addr_o  = sp_q;
  assign mem_wdata_o = ret_q[cnt_q];
  assign load_o      = (state_q == ST_LOAD);
  assign sp_new_o    = sp_q;
  assign gie_clr_o   = load_o;
  assign pend_clr_o  = load_o ? oh_q : '0;
  assign rst_ack_o   = load_o & rst_q;
  assign lat_reset_o = rst_q;
  assign lat_idx_o   = idx_q;
endmodule

// File: rtl/irq_entry_seq.sv
module irq_entry_seq #(
  parameter int          NUM_SRC   = 8,
  parameter int          PC_BYTES  = 3,
  parameter int          SP_W      = 16,
  parameter bit          LONG_JUMP = 1'b1,
  parameter int unsigned VEC_BASE  = 256,
  localparam int PC_W  = 8 * PC_BYTES,
  localparam int IDX_W = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               boundary_i,
  input  logic               skip_i,
  input  logic               gie_i,
  input  logic               rst_req_i,
  input  logic [NUM_SRC-1:0] pend_i,
  input  logic [PC_W-1:0]    pc_i,
  input  logic [SP_W-1:0]    sp_i,
  output logic               busy_o,
  output logic               mem_we_o,
  output logic [SP_W-1:0]    mem_addr_o,
  output logic [7:0]         mem_wdata_o,
  output logic               load_o,
  output logic [PC_W-1:0]    pc_new_o,
  output logic [SP_W-1:0]    sp_new_o,
  output logic               gie_clr_o,
  output logic [NUM_SRC-1:0] pend_clr_o,
  output logic               rst_ack_o
);
  logic               any_pend;
  logic [NUM_SRC-1:0] win_oh;
  logic [IDX_W-1:0]   win_idx;
  logic               idle;
  logic               accept;
  logic               lat_reset;
  logic [IDX_W-1:0]   lat_idx;

  irq_prio_pick #(.NUM_SRC(NUM_SRC)) u_pick (
    .pend_i (pend_i),
    .any_o  (any_pend),
    .oh_o   (win_oh),
    .idx_o  (win_idx)
  );

  // Sample only at a boundary, with interrupts enabled, and never ahead of a skipped instruction
  assign accept = idle & boundary_i & gie_i & ~skip_i & (rst_req_i | any_pend);

  irq_seq_ctrl #(
    .NUM_SRC  (NUM_SRC),
    .PC_BYTES (PC_BYTES),
    .SP_W     (SP_W)
  ) u_ctrl (
    .clk         (clk),
    .rst_n       (rst_n),
    .accept_i    (accept),
    .is_reset_i  (rst_req_i),
    .win_oh_i    (win_oh),
    .win_idx_i   (win_idx),
    .pc_i        (pc_i),
    .sp_i        (sp_i),
    .idle_o      (idle),
    .busy_o      (busy_o),
    .mem_we_o    (mem_we_o),
    .mem_addr_o  (mem_addr_o),
    .mem_wdata_o (mem_wdata_o),
    .load_o      (load_o),
    .sp_new_o    (sp_new_o),
    .gie_clr_o   (gie_clr_o),
    .pend_clr_o  (pend_clr_o),
    .rst_ack_o   (rst_ack_o),
    .lat_reset_o (lat_reset),
    .lat_idx_o   (lat_idx)
  );

  irq_vec_target #(
    .NUM_SRC   (NUM_SRC),
    .PC_W      (PC_W),
    .VEC_BASE  (VEC_BASE),
    .LONG_JUMP (LONG_JUMP)
  ) u_vec (
    .is_reset_i (lat_reset),
    .idx_i      (lat_idx),
    .pc_o       (pc_new_o)
  );
endmodule

// File: rtl/irq_entry_seq_chk.sv
module irq_entry_seq_chk #(
  parameter int NUM_SRC  = 8,
  parameter int PC_BYTES = 3,
  parameter int SP_W     = 16
) (
  input logic               clk,
  input logic               rst_n,
  input logic               boundary_i,
  input logic               skip_i,
  input logic               gie_i,
  input logic               busy_o,
  input logic               mem_we_o,
  input logic [SP_W-1:0]    mem_addr_o,
  input logic               load_o,
  input logic               rst_ack_o,
  input logic [NUM_SRC-1:0] pend_clr_o
);
  int unsigned wr_cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        wr_cnt <= 0;
    else if (load_o)   wr_cnt <= 0;
    else if (mem_we_o) wr_cnt <= wr_cnt + 1;
  end

  // R1 and R10: a sequence starts only from an enabled, unskipped boundary
  assert_accept_gate_R1: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy_o) |-> $past(boundary_i & gie_i & ~skip_i));

  assert_addr_descends_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_we_o && $past(mem_we_o)) |-> mem_addr_o == $past(mem_addr_o) - SP_W'(1));

  assert_write_count_R6: assert property (@(posedge clk) disable iff (!rst_n)
    load_o |-> wr_cnt == PC_BYTES);

  assert_load_follows_push_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(mem_we_o) |-> load_o);

  assert_clear_onehot_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(pend_clr_o) && (pend_clr_o != '0 -> load_o));

  assert_reset_no_clear_R2: assert property (@(posedge clk) disable iff (!rst_n)
    rst_ack_o |-> pend_clr_o == '0);

  assert_busy_covers_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_we_o || load_o) |-> busy_o);

  assert_busy_drops_R9: assert property (@(posedge clk) disable iff (!rst_n)
    load_o |=> !busy_o);
endmodule

bind irq_entry_seq irq_entry_seq_chk #(
  .NUM_SRC  (NUM_SRC),
  .PC_BYTES (PC_BYTES),
  .SP_W     (SP_W)
) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .boundary_i (boundary_i),
  .skip_i     (skip_i),
  .gie_i      (gie_i),
  .busy_o     (busy_o),
  .mem_we_o   (mem_we_o),
  .mem_addr_o (mem_addr_o),
  .load_o     (load_o),
  .rst_ack_o  (rst_ack_o),
  .pend_clr_o (pend_clr_o)
);

// File: tb/test_irq_entry_seq.sv
`timescale 1ns/1ps
module test_irq_entry_seq;
  localparam int NSRC = 8;
  localparam int PCB  = 3;
  localparam int SPW  = 16;
  localparam int BASE = 256;
  localparam int SLOT = 2;

  logic clk = 1'b0;
  logic rst_n;
  logic boundary, skip, gie, rreq;
  logic [NSRC-1:0]  pend;
  logic [8*PCB-1:0] pc;
  logic [SPW-1:0]   sp;
  logic             busy, we, ld, gclr, rack;
  logic [SPW-1:0]   addr, spn;
  logic [7:0]       wdata;
  logic [8*PCB-1:0] pcn;
  logic [NSRC-1:0]  pclr;

  int n_chk = 0;
  int n_fail = 0;

  always #2.5 clk = ~clk;

  irq_entry_seq i_irq_entry_seq (
    .clk(clk), .rst_n(rst_n), .boundary_i(boundary), .skip_i(skip),
    .gie_i(gie), .rst_req_i(rreq), .pend_i(pend), .pc_i(pc), .sp_i(sp),
    .busy_o(busy), .mem_we_o(we), .mem_addr_o(addr), .mem_wdata_o(wdata),
    .load_o(ld), .pc_new_o(pcn), .sp_new_o(spn), .gie_clr_o(gclr),
    .pend_clr_o(pclr), .rst_ack_o(rack)
  );

  task automatic check(string req, string what, longint act, longint exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  // Behavioural reference: phase 0 idle, 1..PCB pushing byte phase-1, PCB+1 load
  int m_phase = 0;
  int m_vec = 0;
  longint m_ret = 0;
  int m_sp = 0;
  bit model_on = 0;

  always @(posedge clk) begin
    if (!rst_n) begin
      m_phase = 0;
    end else if (m_phase == 0) begin
      if (boundary && gie && !skip && (rreq || pend != 0)) begin
        if (rreq) m_vec = 0;
        else begin
          m_vec = -1;
          for (int k = NSRC - 1; k >= 0; k--) if (pend[k]) m_vec = k + 1;
        end
        m_ret = longint'(pc);
        m_sp = int'(sp);
        m_phase = 1;
      end
    end else if (m_phase <= PCB) begin
      m_sp = (m_sp - 1) & ((1 << SPW) - 1);
      m_phase++;
    end else begin
      m_phase = 0;
    end
  end

  always @(negedge clk) begin
    if (model_on) begin
      bit pushing, loading;
      pushing = (m_phase >= 1 && m_phase <= PCB);
      loading = (m_phase == PCB + 1);
      check("R9", "busy", busy, m_phase != 0);
      check("R6", "write strobe", we, pushing);
      check("R7", "load", ld, loading);
      check("R7", "enable clear", gclr, loading);
      if (pushing) begin
        check("R5", "write address", addr, m_sp);
        check("R5", "write byte", wdata, (m_ret >> (8 * (m_phase - 1))) & 8'hff);
      end
      if (loading) begin
        check("R4", "new pc", pcn, BASE + m_vec * SLOT);
        check("R5", "new sp", spn, m_sp);
        check("R2", "reset ack", rack, m_vec == 0);
      end
      check("R8", "pending clear", pclr,
            (loading && m_vec > 0) ? (longint'(1) << (m_vec - 1)) : 0);
    end
  end

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic offer(bit b, bit s, bit g, bit r, logic [NSRC-1:0] p,
                       logic [8*PCB-1:0] pcv, logic [SPW-1:0] spv);
    boundary = b; skip = s; gie = g; rreq = r; pend = p; pc = pcv; sp = spv;
    tick();
    boundary = 0; rreq = 0;
  endtask

  // Offer a request that must be refused, then look at the ports
  task automatic expect_idle(string req);
    @(negedge clk);
    check(req, "busy after refused request", busy, 0);
    check(req, "write after refused request", we, 0);
    tick();
  endtask

  task automatic expect_target(string req, int vec);
    bit seen = 0;
    for (int c = 0; c < 10 && !seen; c++) begin
      @(negedge clk);
      if (ld) begin
        seen = 1;
        check(req, "vector target", pcn, BASE + vec * SLOT);
      end
    end
    if (!seen) check(req, "load pulse seen", 0, 1);
    tick();
  endtask

  initial begin
    #200000;
    n_fail++;
    $display("FAIL watchdog: actual hung expected done");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    rst_n = 0; boundary = 0; skip = 0; gie = 0; rreq = 0;
    pend = '0; pc = '0; sp = '0;
    repeat (3) tick();
    @(negedge clk);
    check("R9", "busy in reset", busy, 0);
    check("R6", "write in reset", we, 0);
    check("R7", "load in reset", ld, 0);
    rst_n = 1;
    tick();
    model_on = 1;

    // R1: the enable flag gates both kinds of request
    offer(1, 0, 0, 0, 8'h10, 24'h012345, 16'h08ff); expect_idle("R1");
    offer(1, 0, 0, 1, 8'h00, 24'h012345, 16'h08ff); expect_idle("R1");
    offer(1, 0, 1, 0, 8'h00, 24'h012345, 16'h08ff); expect_idle("R1");
    offer(0, 0, 1, 0, 8'h01, 24'h012345, 16'h08ff); expect_idle("R1");
    // R10: no entry ahead of a skipped instruction
    offer(1, 1, 1, 0, 8'h01, 24'h012345, 16'h08ff); expect_idle("R10");
    offer(1, 1, 1, 1, 8'h00, 24'h012345, 16'h08ff); expect_idle("R10");

    // R3: lowest set bit wins
    offer(1, 0, 1, 0, 8'b0001_0100, 24'habcdef, 16'h08ff); expect_target("R3", 3);
    offer(1, 0, 1, 0, 8'h80, 24'h3c5a96, 16'h0100);        expect_target("R3", 8);
    offer(1, 0, 1, 0, 8'hff, 24'h000001, 16'h0000);        expect_target("R3", 1);

    // R2: reset request beats every source
    offer(1, 0, 1, 1, 8'hff, 24'h7e0102, 16'h1234);        expect_target("R2", 0);

    // R9: strobes while busy are ignored
    offer(1, 0, 1, 0, 8'h40, 24'h112233, 16'h0400);
    boundary = 1; rreq = 1; pend = 8'h01;
    repeat (3) tick();
    boundary = 0; rreq = 0;
    expect_target("R9", 7);

    // Back-to-back: a new request right after the sequence ends
    offer(1, 0, 1, 0, 8'h02, 24'hfedcba, 16'hffff);        expect_target("R4", 2);
    repeat (4) tick();

    model_on = 0;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule